// File: doc/BRIEF.md
# Interleaved MSI Vector Interrupt Controller

This block collects message-signalled interrupts for a host bridge and fans them out onto eight interrupt lines. Thirty-two vectors are spread across eight groups of four pending bits. The spread is interleaved: vector `v` belongs to group `v mod 8` and sits at bit `v div 8` of that group. Group 0 therefore holds vectors 0, 8, 16 and 24. An MSI arrives either as a one-cycle strobe carrying the vector number, or as a register write whose low five data bits name the vector. In both cases the vector's pending bit is set whether or not the vector is enabled.

Software works each group through three registers on a simple write/read port. A status register returns the raw pending bits and clears each bit written with a one. An enable-set register and an enable-clear register change the enable mask, and reading either one returns the mask. Each group drives a one-cycle pulse on its line when it is armed and holds a pending bit that is also enabled. The pulse disarms the group. Writing `g+4` to the end-of-interrupt register re-arms group `g`. If enabled pending bits remain at that point, the group pulses again. The end-of-interrupt values 0 to 3 belong to legacy lines and have no effect here.

Top module: `msi_group_irq`

## Requirements
- R1: After reset, every pending and enable bit is 0, every line is low and every group is armed.
- R2: Vector v sets bit v div 8 of group v mod 8. The pending bits of group g are read in bits 3:0 at address 0x104+16*g.
- R3: A strobe on `msi_valid`, or a bus write to address 0x054 (vector = data bits 4:0), sets that vector's pending bit at the next clock edge, regardless of its enable bit.
- R4: A one in bit b written to 0x108+16*g enables bit b of group g. A one written to 0x10C+16*g disables it. Zeros leave bits unchanged. Reading either address returns the group's 4-bit enable mask in bits 3:0.
- R5: A one in bit b written to 0x104+16*g clears that pending bit. Zero bits leave pending bits unchanged.
- R6: If an MSI and a write-one-to-clear hit the same pending bit in the same cycle, the bit ends set.
- R7: `irq_o[g]` goes high for exactly one cycle, in the cycle after one in which group g is armed and has a pending bit that is also enabled. Firing disarms the group.
- R8: Writing the value g+4 to 0x050 re-arms group g. Any other value (0 to 3 or 12 and above) re-arms no group.
- R9: Pending bits that are not enabled never raise a line. Enabling such a bit in an armed group raises the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address (write and read) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| msi_valid | input | 1 | MSI arrival strobe |
| msi_vec | input | 5 | Vector number of the arriving MSI |
| irq_o | output | 8 | Per-group interrupt pulses |

## Verification
The hardest situation to reach is a group that is re-armed by end-of-interrupt while enabled bits are still pending, in the same window where an MSI races a write-one-to-clear on the same bit. A directed sequence sets this up on group 1. It fires the group, leaves the vector pending, re-arms the group with the correct value and with the legacy and out-of-range values, and then issues the clear and the MSI together. Several thousand random cycles follow. They mix strobes, register MSIs, enable changes, clears and end-of-interrupt values, and a bench reference model predicts every line and every register read-back.

// File: rtl/msi_group_irq.sv
module msi_group_irq #(
  parameter int NUM_GRP  = 8,
  parameter int GRP_BITS = 4,
  parameter int AW       = 12,
  parameter int DW       = 32,
  parameter int EOI_BASE = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_we,
  input  logic [AW-1:0]                bus_addr,
  input  logic [DW-1:0]                bus_wdata,
  output logic [DW-1:0]                bus_rdata,
  input  logic                         msi_valid,
  input  logic [$clog2(NUM_GRP*GRP_BITS)-1:0] msi_vec,
  output logic [NUM_GRP-1:0]           irq_o
);
  localparam int NVEC = NUM_GRP * GRP_BITS;
  localparam int VW   = $clog2(NVEC);
  localparam int GW   = $clog2(NUM_GRP);
  localparam logic [AW-1:0] A_EOI  = AW'('h050);
  localparam logic [AW-1:0] A_MSI  = AW'('h054);
  localparam logic [AW-1:0] A_GRP  = AW'('h100);
  localparam logic [3:0]    S_STAT = 4'h4;
  localparam logic [3:0]    S_SET  = 4'h8;
  localparam logic [3:0]    S_CLR  = 4'hC;

  logic [NVEC-1:0]    pend_q, en_q, msi_set, w1c, ens, enc;
  logic [NUM_GRP-1:0] armed, active, fire, eoi_hit, irq_q;

  wire              in_grp  = bus_addr[AW-1:GW+4] == A_GRP[AW-1:GW+4];
  wire [GW-1:0]     sel     = bus_addr[GW+3:4];
  wire [3:0]        sub     = bus_addr[3:0];
  wire              msi_reg = bus_we && bus_addr == A_MSI;
  wire [VW-1:0]     reg_vec = bus_wdata[VW-1:0];

  function automatic int vidx(input logic [VW-1:0] v);
    return int'(v[GW-1:0]) * GRP_BITS + int'(v[VW-1:GW]);
  endfunction

  always_comb begin
    msi_set = '0;
    if (msi_valid) msi_set[vidx(msi_vec)] = 1'b1;
    if (msi_reg)   msi_set[vidx(reg_vec)] = 1'b1;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_GRP; g++) begin : grp
      wire hit = bus_we && in_grp && sel == GW'(g);
      assign w1c[g*GRP_BITS +: GRP_BITS] = (hit && sub == S_STAT) ? bus_wdata[GRP_BITS-1:0] : '0;
      assign ens[g*GRP_BITS +: GRP_BITS] = (hit && sub == S_SET)  ? bus_wdata[GRP_BITS-1:0] : '0;
      assign enc[g*GRP_BITS +: GRP_BITS] = (hit && sub == S_CLR)  ? bus_wdata[GRP_BITS-1:0] : '0;
      assign eoi_hit[g] = bus_we && bus_addr == A_EOI && bus_wdata == DW'(g + EOI_BASE);
      assign active[g]  = |(pend_q[g*GRP_BITS +: GRP_BITS] & en_q[g*GRP_BITS +: GRP_BITS]);

      p_irq_needs_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[g] |-> $past(|(pend_q[g*GRP_BITS +: GRP_BITS] & en_q[g*GRP_BITS +: GRP_BITS])));
      p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[g] && !$past(eoi_hit[g]) |=> !irq_o[g]);
    end
  endgenerate

  assign fire = armed & active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      armed  <= '1;
      irq_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~w1c) | msi_set;
      en_q   <= (en_q | ens) & ~enc;
      armed  <= eoi_hit | (armed & ~fire);
      irq_q  <= fire;
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (in_grp) begin
      if (sub == S_STAT)
        bus_rdata[GRP_BITS-1:0] = pend_q[int'(sel)*GRP_BITS +: GRP_BITS];
      else if (sub == S_SET || sub == S_CLR)
        bus_rdata[GRP_BITS-1:0] = en_q[int'(sel)*GRP_BITS +: GRP_BITS];
    end
  end

  p_msi_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    msi_valid |=> pend_q[$past(vidx(msi_vec))]);

  genvar b;
  generate
    for (b = 0; b < NVEC; b++) begin : bitchk
      p_enable_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ens[b] |=> en_q[b]);
      p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        w1c[b] && !msi_set[b] |=> !pend_q[b]);
      p_msi_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        w1c[b] && msi_set[b] |=> pend_q[b]);
    end
  endgenerate
endmodule

// File: tb/msi_group_irq_test.sv
`timescale 1ns/1ps
module msi_group_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        msi_valid = 1'b0;
  logic [4:0]  msi_vec = '0;
  logic [7:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit [31:0] m_pend, m_en;
  bit [7:0]  m_arm;

  always #4 clk = ~clk;

  msi_group_irq uut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .msi_valid(msi_valid),
    .msi_vec(msi_vec), .irq_o(irq_o));

  function automatic int vidx(input bit [4:0] v);
    return int'(v % 8) * 4 + int'(v / 8);
  endfunction

  function automatic bit [31:0] mread(input bit [11:0] a);
    int g;
    g = int'(a[6:4]);
    if (a[11:7] != 5'd2) return 0;
    if (a[3:0] == 4'h4) return {28'd0, m_pend[g*4 +: 4]};
    if (a[3:0] == 4'h8 || a[3:0] == 4'hC) return {28'd0, m_en[g*4 +: 4]};
    return 0;
  endfunction

  task automatic chk(input string tag, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit we, input bit [11:0] a, input bit [31:0] d,
                      input bit mv, input bit [4:0] vec, input string tag);
    bit [7:0] f;
    bit [31:0] clr, set;
    bus_we = we; bus_addr = a; bus_wdata = d; msi_valid = mv; msi_vec = vec;
    for (int g = 0; g < 8; g++) f[g] = m_arm[g] && (((m_pend & m_en) >> (g*4)) & 32'hF) != 0;
    clr = 0; set = 0;
    if (mv) set[vidx(vec)] = 1;
    if (we && a == 12'h054) set[vidx(d[4:0])] = 1;
    if (we && a[11:7] == 5'd2) begin
      if (a[3:0] == 4'h4) clr[int'(a[6:4])*4 +: 4] = d[3:0];
      if (a[3:0] == 4'h8) m_en[int'(a[6:4])*4 +: 4] |= d[3:0];
      if (a[3:0] == 4'hC) m_en[int'(a[6:4])*4 +: 4] &= ~d[3:0];
    end
    m_pend = (m_pend & ~clr) | set;
    for (int g = 0; g < 8; g++)
      m_arm[g] = (we && a == 12'h050 && d == 32'(g + 4)) ? 1'b1 : (m_arm[g] && !f[g]);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R7 irq"}, {24'd0, irq_o}, {24'd0, f});
    bus_we = 0; msi_valid = 0;
  endtask

  task automatic rd(input bit [11:0] a, input string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, mread(a));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 12'h0, 0, 0, 0, "idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [31:0] r;
    r = $urandom(32'h5eed);
    m_pend = 0; m_en = 0; m_arm = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", {24'd0, irq_o}, 0);
    for (int g = 0; g < 8; g++) begin
      rd(12'h104 + 12'(16*g), "R1 status");
      rd(12'h108 + 12'(16*g), "R1 enable");
    end
    // R2 interleaved mapping: vector 19 -> group 3 bit 2
    step(0, 0, 0, 1, 5'd19, "R2");
    bus_addr = 12'h134; #1; chk("R2 status g3", bus_rdata, 32'h4);
    // R3 register MSI, upper data bits ignored: vector 9 -> group 1 bit 1
    step(1, 12'h054, 32'hFFFF_FFE9, 0, 0, "R3");
    bus_addr = 12'h114; #1; chk("R3 status g1", bus_rdata, 32'h2);
    // R9 disabled pending stays quiet
    idle(2);
    chk("R9 quiet", {24'd0, irq_o}, 0);
    // R4 enable then R9 line rises
    step(1, 12'h118, 32'h2, 0, 0, "R4");
    bus_addr = 12'h118; #1; chk("R4 set read", bus_rdata, 32'h2);
    bus_addr = 12'h11C; #1; chk("R4 clr read", bus_rdata, 32'h2);
    step(0, 0, 0, 0, 0, "R9 fire");
    chk("R9 pulse g1", {24'd0, irq_o}, 32'h2);
    step(0, 0, 0, 0, 0, "R7 one cycle");
    chk("R7 low after pulse", {24'd0, irq_o}, 0);
    // R8 legacy and out-of-range EOI values ignored
    step(1, 12'h050, 32'd1, 0, 0, "R8 legacy");
    step(1, 12'h050, 32'd12, 0, 0, "R8 range");
    idle(2);
    chk("R8 no rearm", {24'd0, irq_o}, 0);
    step(1, 12'h050, 32'd5, 0, 0, "R8 eoi");
    step(0, 0, 0, 0, 0, "R8 refire");
    chk("R8 pulse again", {24'd0, irq_o}, 32'h2);
    // R5 write zero no effect, then W1C
    step(1, 12'h114, 32'h0, 0, 0, "R5 zero");
    rd(12'h114, "R5 zero write");
    chk("R5 still pending", bus_rdata, 32'h2);
    // R6 MSI beats clear
    step(1, 12'h114, 32'h2, 1, 5'd9, "R6");
    bus_addr = 12'h114; #1; chk("R6 msi wins", bus_rdata, 32'h2);
    step(1, 12'h114, 32'h2, 0, 0, "R5 clear");
    bus_addr = 12'h114; #1; chk("R5 cleared", bus_rdata, 32'h0);
    step(1, 12'h11C, 32'hF, 0, 0, "R4 clear");
    rd(12'h118, "R4 disabled");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int op;
      bit [2:0] g;
      op = int'($urandom % 7);
      g = 3'($urandom);
      case (op)
        0: step(0, 0, 0, 1, 5'($urandom), "rand msi");
        1: step(1, 12'h104 + 12'(16*g), $urandom, $urandom % 3 == 0, 5'($urandom), "rand R5 w1c");
        2: step(1, 12'h108 + 12'(16*g), $urandom, 0, 0, "rand R4 set");
        3: step(1, 12'h10C + 12'(16*g), $urandom % 4 == 0 ? 32'hF : 32'h0, 0, 0, "rand R4 clr");
        4: step(1, 12'h050, $urandom % 14, 0, 0, "rand R8 eoi");
        5: step(1, 12'h054, $urandom, 1, 5'($urandom), "rand R3 reg msi");
        default: step(0, 0, 0, 0, 0, "rand idle");
      endcase
      if (i % 4 == 0) rd(12'h100 + 12'(16*($urandom % 8)) + 12'(4*($urandom % 4)), "rand R2 read");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule